// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an SPI host read and write a bank of 32 eight-bit control registers that lives in the surrounding core. The host lowers chip select and sends a header word. The header either names a command or opens a register access. For a register access it also selects read or write and picks one of two access styles. In single style, header words and data bytes alternate for as long as chip select stays low. In continuous style, one header is followed by any number of data bytes at rising, wrapping addresses.

The serial pins are sampled in the system clock domain. The core sees a plain register port: an address, write data with a write strobe, and read data that is taken when the read strobe is high. Reads can have side effects in the core, for example a status register that clears itself. For that reason the slave issues a read strobe only for a byte the host has actually started to clock. It never reads ahead. Command headers do not touch the bank. They produce a one-cycle strobe that carries the command code.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `reg_we`, `reg_re`, `cmd_stb`, `miso` and `miso_oe` are all 0.
- R2: Every word is 8 bits long and travels most significant bit first. The host changes MOSI on the rising SCLK edge, and the slave takes each bit on the falling edge.
- R3: Header layout. Bit 7 = 1 marks a command, and bits 4..0 then hold the command code. Bit 7 = 0 marks a register access, where bit 6 = 1 means read, bit 5 = 1 means continuous style, and bits 4..0 give the start address.
- R4: A write data byte produces exactly one `reg_we` pulse, carrying the current address and the received byte. `reg_we` and `reg_re` are never high in the same cycle.
- R5: In a read access, the addressed register is presented on MISO, MSB first, during the byte that follows the header. Exactly one `reg_re` pulse is issued per data byte, at the first rising SCLK edge of that byte, so no register is read ahead.
- R6: In continuous style, the first data byte uses the header address and each later byte uses the next address. Address 31 wraps to 0.
- R7: A register that the core clears on `reg_re` (address 0x0C in the bench core) returns its value on the first read and 0 after that. A continuous read that starts at 0x0C with one dummy byte returns 0x0C and then 0x0D, and clears only 0x0C.
- R8: A command header with a nonzero code gives one `cmd_stb` pulse that lasts one cycle, with `cmd_code` equal to bits 4..0. No `reg_we` or `reg_re` pulse is issued.
- R9: Command code 0 (header 0x80) is idle. It gives no strobe of any kind, and the next byte is taken as a new header.
- R10: If chip select rises in the middle of a byte, that partial byte is discarded with no write. The next transaction starts cleanly with a header.
- R11: If the final falling SCLK edge of a byte and the rise of chip select arrive together, the completed byte is still committed.
- R12: While chip select is high, `miso_oe` and `miso` are both 0. While it is low, `miso_oe` is 1, and MISO is 0 during header bytes and write data bytes.
- R13: In single style, several header/data pairs may follow one another in one select. This includes a write pair followed by a read pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | High while the slave drives MISO |
| reg_addr | output | 5 | Register address toward the core |
| reg_wdata | output | 8 | Write data toward the core |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe; data is taken in the same cycle |
| reg_rdata | input | 8 | Read data from the core for `reg_addr` |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 5 | Code of the last command |

## Verification
The completion of a byte on the final falling SCLK edge and the end of the frame on the rising chip select can reach the synchronized logic in the same system clock cycle. To provoke this, the bench lowers SCLK and raises chip select in the same host step at the end of a write data byte. It judges the result by whether the core model's register holds the byte afterwards. The bench also checks that the following transaction still decodes its first byte as a header.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned ADDR_W = 5;

  typedef struct packed {
    logic              is_cmd;
    logic              is_read;
    logic              is_cont;
    logic [ADDR_W-1:0] addr;
  } hdr_t;

  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // Split a received header word into its fields.
  function automatic hdr_t decode_hdr(input logic [WORD_W-1:0] w);
    hdr_t h;
    h.is_cmd  = w[7];
    h.is_read = w[6];
    h.is_cont = w[5];
    h.addr    = w[ADDR_W-1:0];
    return h;
  endfunction

  // Continuous-style address step, wrapping at the top of the bank.
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int unsigned   W       = 3,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] lvl
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else        chain <= {chain[STAGES-2:0], d_async[i]};
      end
      assign lvl[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_rb_rx.sv
module spi_rb_rx
  import spi_rb_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 smp,
  input  logic                 din,
  output logic [$clog2(W)-1:0] bit_cnt,
  output logic                 byte_done,
  output logic [W-1:0]         byte_val
);
  localparam int unsigned CNT_W = $clog2(W);

  logic [W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
    end else if (smp) begin
      sh      <= {sh[W-3:0], din};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign byte_done = smp && (bit_cnt == CNT_W'(W-1));
  assign byte_val  = {sh, din};
endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
  import spi_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_done,
  input  logic [WORD_W-1:0] byte_val,
  input  logic              rd_slot,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_code,
  output logic [ADDR_W-1:0] ptr,
  output logic              data_phase,
  output logic              cont_mode
);
  phase_e phase;
  logic   rd_mode;
  hdr_t   hdr;

  assign hdr = decode_hdr(byte_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_HDR;
      rd_mode   <= 1'b0;
      cont_mode <= 1'b0;
      ptr       <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      cmd_stb   <= 1'b0;
      cmd_code  <= '0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      cmd_stb <= 1'b0;
      if (byte_done) begin
        if (phase == PH_HDR) begin
          if (hdr.is_cmd) begin
            if (hdr.addr != '0) begin
              cmd_stb  <= 1'b1;
              cmd_code <= hdr.addr;
            end
          end else begin
            phase     <= PH_DATA;
            rd_mode   <= hdr.is_read;
            cont_mode <= hdr.is_cont;
            ptr       <= hdr.addr;
          end
        end else begin
          if (!rd_mode) begin
            reg_we    <= 1'b1;
            reg_addr  <= ptr;
            reg_wdata <= byte_val;
          end
          if (cont_mode) ptr   <= next_addr(ptr);
          else           phase <= PH_HDR;
        end
      end
      if (rd_slot && phase == PH_DATA && rd_mode) begin
        reg_re   <= 1'b1;
        reg_addr <= ptr;
      end
      if (clr) begin
        phase     <= PH_HDR;
        rd_mode   <= 1'b0;
        cont_mode <= 1'b0;
      end
    end
  end

  assign data_phase = (phase == PH_DATA);
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx
  import spi_rb_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (!active) sh <= '0;
    else if (load)   sh <= ldata;
    else if (shift)  sh <= {sh[W-2:0], 1'b0};
  end

  assign bit_out = sh[W-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_rb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_code
);
  localparam int unsigned IX_SCLK = 0;
  localparam int unsigned IX_CS   = 1;
  localparam int unsigned IX_MOSI = 2;
  localparam int unsigned CNT_W   = $clog2(WORD_W);

  logic [2:0]        pin_lvl;
  logic              sclk_q;
  logic              cs_q;
  logic              sel_now;
  logic              sel_was;
  logic              sclk_fall_evt;
  logic              sclk_rise_evt;
  logic              frame_edge;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_done;
  logic [WORD_W-1:0] byte_val;
  logic              rd_slot;
  logic [ADDR_W-1:0] ptr;
  logic              data_phase;
  logic              cont_mode;
  logic              tx_bit;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({mosi, cs_n, sclk}),
    .lvl     (pin_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= pin_lvl[IX_SCLK];
      cs_q   <= pin_lvl[IX_CS];
    end
  end

  assign sel_now       = ~pin_lvl[IX_CS];
  assign sel_was       = ~cs_q;
  assign sclk_fall_evt = sclk_q & ~pin_lvl[IX_SCLK] & sel_was;
  assign sclk_rise_evt = ~sclk_q & pin_lvl[IX_SCLK] & sel_was;
  assign frame_edge    = cs_q ^ pin_lvl[IX_CS];
  assign rd_slot       = sclk_rise_evt & (bit_cnt == '0);

  spi_rb_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (frame_edge),
    .smp       (sclk_fall_evt),
    .din       (pin_lvl[IX_MOSI]),
    .bit_cnt   (bit_cnt),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  spi_rb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (frame_edge),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .rd_slot    (rd_slot),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .cmd_stb    (cmd_stb),
    .cmd_code   (cmd_code),
    .ptr        (ptr),
    .data_phase (data_phase),
    .cont_mode  (cont_mode)
  );

  spi_rb_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (sel_now),
    .load    (reg_re),
    .ldata   (reg_rdata),
    .shift   (sclk_rise_evt),
    .bit_out (tx_bit)
  );

  assign miso    = sel_now & tx_bit;
  assign miso_oe = sel_now;
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk
  import spi_rb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              miso,
  input logic              miso_oe,
  input logic              reg_we,
  input logic              reg_re,
  input logic              cmd_stb,
  input logic [ADDR_W-1:0] cmd_code,
  input logic              byte_done,
  input logic              data_phase,
  input logic              cont_mode,
  input logic [ADDR_W-1:0] ptr
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re)); // R4
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re); // R5
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R8
  AST_CMD_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (!reg_we && !reg_re)); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (cmd_code != '0)); // R9
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso); // R12
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && data_phase && cont_mode) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R6
endmodule

bind spi_reg_slave spi_rb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miso       (miso),
  .miso_oe    (miso_oe),
  .reg_we     (reg_we),
  .reg_re     (reg_re),
  .cmd_stb    (cmd_stb),
  .cmd_code   (cmd_code),
  .byte_done  (byte_done),
  .data_phase (data_phase),
  .cont_mode  (cont_mode),
  .ptr        (ptr)
);

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
  localparam int H = 8;

  typedef struct packed {
    logic [7:0] hdr;
    logic [7:0] dat;
    logic [7:0] exp;
  } vec_t;

  // single-style pairs; writes check the core model, reads check MISO
  localparam vec_t VECS [9] = '{
    '{8'h03, 8'h5A, 8'h5A},
    '{8'h43, 8'h00, 8'h5A},
    '{8'h1F, 8'hC3, 8'hC3},
    '{8'h5F, 8'h00, 8'hC3},
    '{8'h0C, 8'h81, 8'h81},
    '{8'h4C, 8'h00, 8'h81},
    '{8'h4C, 8'h00, 8'h00},
    '{8'h00, 8'hFF, 8'hFF},
    '{8'h40, 8'h00, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  wire        miso;
  wire        miso_oe;
  wire [4:0]  reg_addr;
  wire [7:0]  reg_wdata;
  wire        reg_we;
  wire        reg_re;
  wire [7:0]  reg_rdata;
  wire        cmd_stb;
  wire [4:0]  cmd_code;

  logic [7:0] bank [32];
  int         we_cnt;
  int         re_cnt;
  int         cmd_cnt;
  logic [4:0] last_code;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  spi_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code)
  );

  // core model: plain bank, 0x0C clears when read
  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) bank[i] <= 8'h00;
      we_cnt <= 0; re_cnt <= 0; cmd_cnt <= 0; last_code <= 5'd0;
    end else begin
      if (reg_we) bank[reg_addr] <= reg_wdata;
      else if (reg_re && reg_addr == 5'h0C) bank[5'h0C] <= 8'h00;
      if (reg_we) we_cnt <= we_cnt + 1;
      if (reg_re) re_cnt <= re_cnt + 1;
      if (cmd_stb) begin cmd_cnt <= cmd_cnt + 1; last_code <= cmd_code; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit end_cs);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b0;
      if (i == 0 && end_cs) cs_n = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] got;
    int c0;
    int c1;
    int c2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 miso", miso, 0);
    chk("R1 miso_oe", miso_oe, 0);
    chk("R1 strobes", {reg_we, reg_re, cmd_stb}, 0);

    // table walk: R2 bit order, R3 header, R4 writes, R5 reads, R7 clear, R13
    for (int k = 0; k < 9; k++) begin
      sel();
      chk("R12 oe while selected", miso_oe, 1);
      xfer(VECS[k].hdr, got, 1'b0);
      chk("R12 miso during header", got, 0);
      xfer(VECS[k].dat, got, 1'b0);
      desel();
      if (VECS[k].hdr[6]) chk(k == 6 ? "R7 cleared on read" : "R5 R2 read", got, VECS[k].exp);
      else chk("R4 R3 write", bank[VECS[k].hdr[4:0]], VECS[k].exp);
    end
    chk("R12 miso idle", {miso, miso_oe}, 0);

    // R6 continuous write, MISO quiet (R12)
    sel();
    xfer(8'h25, got, 1'b0);
    xfer(8'h11, got, 1'b0); chk("R12 miso in write", got, 0);
    xfer(8'h22, got, 1'b0);
    xfer(8'h33, got, 1'b0);
    desel();
    chk("R6 cont write", {bank[5], bank[6], bank[7]}, 32'h112233);

    // R5 R6 continuous read, one strobe per byte
    c0 = re_cnt;
    sel();
    xfer(8'h65, got, 1'b0); chk("R5 no read in header", re_cnt - c0, 0);
    xfer(8'h00, got, 1'b0); chk("R6 cont read 0", got, 8'h11);
    xfer(8'h00, got, 1'b0); chk("R6 cont read 1", got, 8'h22);
    xfer(8'h00, got, 1'b0); chk("R6 cont read 2", got, 8'h33);
    desel();
    chk("R5 read strobes", re_cnt - c0, 3);

    // R6 wrap 31 -> 0
    sel();
    xfer(8'h3F, got, 1'b0);
    xfer(8'hAA, got, 1'b0);
    xfer(8'hBB, got, 1'b0);
    desel();
    chk("R6 wrap top", bank[31], 8'hAA);
    chk("R6 wrap zero", bank[0], 8'hBB);

    // R13 several single pairs in one select
    sel();
    xfer(8'h08, got, 1'b0); xfer(8'h77, got, 1'b0);
    xfer(8'h09, got, 1'b0); xfer(8'h66, got, 1'b0);
    xfer(8'h48, got, 1'b0); xfer(8'h00, got, 1'b0);
    desel();
    chk("R13 pair 1", bank[8], 8'h77);
    chk("R13 pair 2", bank[9], 8'h66);
    chk("R13 read pair", got, 8'h77);

    // R8 command
    c0 = cmd_cnt; c1 = we_cnt; c2 = re_cnt;
    sel();
    xfer(8'h94, got, 1'b0);
    desel();
    chk("R8 cmd count", cmd_cnt - c0, 1);
    chk("R8 cmd code", last_code, 5'h14);
    chk("R8 no bank access", (we_cnt - c1) + (re_cnt - c2), 0);

    // R9 idle, then header decoded again
    c0 = cmd_cnt; c1 = we_cnt;
    sel();
    xfer(8'h80, got, 1'b0);
    chk("R9 idle no strobe", cmd_cnt - c0, 0);
    chk("R9 idle no write", we_cnt - c1, 0);
    xfer(8'h02, got, 1'b0); xfer(8'h44, got, 1'b0);
    desel();
    chk("R9 next is header", bank[2], 8'h44);

    // R10 abort mid byte
    c1 = we_cnt;
    sel();
    xfer(8'h0A, got, 1'b0);
    bits(8'hF0, 4);
    desel();
    chk("R10 partial dropped", bank[10], 8'h00);
    chk("R10 no write", we_cnt - c1, 0);
    sel();
    xfer(8'h0A, got, 1'b0); xfer(8'h12, got, 1'b0);
    desel();
    chk("R10 clean restart", bank[10], 8'h12);

    // R11 final edge together with deselect
    sel();
    xfer(8'h0B, got, 1'b0);
    xfer(8'h3C, got, 1'b1);
    repeat (2*H) @(negedge clk);
    chk("R11 coincident commit", bank[11], 8'h3C);
    sel();
    xfer(8'h0E, got, 1'b0); xfer(8'h5D, got, 1'b0);
    desel();
    chk("R11 next frame header", bank[14], 8'h5D);

    // R7 status read with dummy byte
    sel();
    xfer(8'h2C, got, 1'b0); xfer(8'h40, got, 1'b0); xfer(8'h9E, got, 1'b0);
    desel();
    sel();
    xfer(8'h6C, got, 1'b0);
    xfer(8'h00, got, 1'b0); chk("R7 status value", got, 8'h40);
    xfer(8'h00, got, 1'b0); chk("R7 dummy byte", got, 8'h9E);
    desel();
    chk("R7 status cleared", bank[12], 8'h00);
    chk("R7 neighbour kept", bank[13], 8'h9E);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule